// File: doc/BRIEF.md
# Vectored interrupt priority tracker

This block keeps three 256-entry bit maps for a processor's interrupt controller: which vectors are waiting, which are being serviced, and which waiting or serviced vectors arrived level-triggered. From the serviced map and a programmable task priority it derives the processor priority. It then offers the highest waiting vector to the core only when that vector's priority class (its upper four bits) beats the processor priority.

The surrounding controller feeds accepted interrupts into the accept port and writes the task priority, either as a full byte or as a 4-bit class. It pulses acknowledge when the core takes the offered vector and pulses end-of-interrupt when the handler finishes. End-of-interrupt retires the highest serviced vector. If that vector was level-triggered, the block sends out a one-cycle notice carrying the vector, so the interrupt source can re-sample its line. A global enable, the AND of a hardware and a software enable, gates both acceptance and delivery.

Top module: `vec_prio_tracker`

## Requirements
- R1: After reset all three maps are empty and the task priority is 0. `irq_valid_o`, `ppr_o`, `cls_o`, `acc_taken_o`, `acc_drop_o` and `eoi_bc_o` are all 0.
- R2: An accept sets the vector's pending bit and pulses `acc_taken_o` in the next cycle. It applies only while enabled and only for a vector of 16 or above. Level (`acc_level_i`=1) marks the vector level-triggered and edge (0) marks it edge-triggered. `irq_vec_o` always shows the highest pending vector.
- R3: A level accept for a vector that is already pending is discarded and `acc_drop_o` pulses. An edge accept for a pending vector is taken and marks it edge-triggered.
- R4: While `hw_en_i` AND `sw_en_i` is false, accepts are dropped and `irq_valid_o` stays low. An accept for a vector below 16 is always dropped.
- R5: `ppr_o` equals the task priority when the task priority's class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that vector with bits 3:0 cleared. An empty in-service map counts as vector 0.
- R6: `irq_valid_o` is 1 exactly when the block is enabled, something is pending, and (highest pending AND 0xF0) is strictly greater than `ppr_o`.
- R7: `ack_i` while `irq_valid_o` is 1 moves `irq_vec_o` from pending to in-service. `ack_i` while `irq_valid_o` is 0 changes nothing.
- R8: `eoi_i` clears the highest in-service vector. If that vector was level-triggered, its trigger bit is cleared and `eoi_bc_o` pulses for one cycle with `eoi_bc_vec_o` set to the vector. Edge-triggered vectors give no pulse. With nothing in service, `eoi_i` has no effect.
- R9: `tpr_we_i` loads the full byte `tpr_i`. `cls_we_i` loads `cls_i` shifted left by 4. `cls_o` returns task priority bits 7:4. When both write strobes are high in the same cycle, the full-byte write wins.
- R10: When an acknowledge and an accept for the same vector fall in the same cycle, the acknowledge clear is applied first. The vector therefore becomes in-service and stays pending, and a level accept in that case is taken.
- R11: Every output reflects a request in the first cycle after the clock edge that captures it, and the result holds under any mix of simultaneous accept, acknowledge, end-of-interrupt and priority writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_en_i | input | 1 | Hardware enable |
| sw_en_i | input | 1 | Software enable |
| acc_valid_i | input | 1 | Accept request |
| acc_vec_i | input | 8 | Vector to accept |
| acc_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acc_taken_o | output | 1 | Accept was taken (one cycle later) |
| acc_drop_o | output | 1 | Accept was discarded (one cycle later) |
| tpr_we_i | input | 1 | Full task-priority write |
| tpr_i | input | 8 | Task priority byte |
| cls_we_i | input | 1 | Class-only task-priority write |
| cls_i | input | 4 | Task priority class |
| cls_o | output | 4 | Task priority bits 7:4 |
| ack_i | input | 1 | Core takes the offered vector |
| eoi_i | input | 1 | End of interrupt |
| irq_valid_o | output | 1 | A deliverable vector is offered |
| irq_vec_o | output | 8 | Highest pending vector |
| ppr_o | output | 8 | Processor priority |
| eoi_bc_o | output | 1 | Level-triggered end-of-interrupt notice |
| eoi_bc_vec_o | output | 8 | Vector of the notice |

## Verification
An acknowledge and an accept can land on the same vector in one cycle. The bench makes a vector deliverable and then raises `ack_i` together with `acc_valid_i` for that vector. It then requires the vector to be in service and still pending, so it is offered again after end-of-interrupt. End-of-interrupt can also coincide with acknowledge and with accepts that rewrite the retiring vector's trigger bit. A stretch of random mixed traffic drives all four operations at once. A behavioural model, applying the same ordering, judges every output on every cycle.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int VEC_W   = 8;
  localparam int CLS_W   = 4;
  localparam int NUM_VEC = 1 << VEC_W;

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic hit;
    vec_t idx;
  } find_t;
endpackage

// File: rtl/vpt_map.sv
module vpt_map
  import vpt_pkg::*;
#(
  parameter int NUM    = NUM_VEC,
  parameter int WORD_W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_en_i,
  input  vec_t           clr_idx_i,
  input  logic           wr_en_i,
  input  vec_t           wr_idx_i,
  input  logic           wr_val_i,
  output logic [NUM-1:0] map_o
);
  localparam int WORDS = NUM / WORD_W;
  localparam int BIT_W = $clog2(WORD_W);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] q, d;
    logic clr_hit, wr_hit;
    assign clr_hit = clr_en_i && (int'(clr_idx_i[VEC_W-1:BIT_W]) == g);
    assign wr_hit  = wr_en_i  && (int'(wr_idx_i[VEC_W-1:BIT_W])  == g);

    // clear first, then write: write wins on the same bit
    always_comb begin
      d = q;
      if (clr_hit) d[clr_idx_i[BIT_W-1:0]] = 1'b0;
      if (wr_hit)  d[wr_idx_i[BIT_W-1:0]]  = wr_val_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    assign map_o[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/vpt_find.sv
module vpt_find
  import vpt_pkg::*;
#(
  parameter int NUM    = NUM_VEC,
  parameter int WORD_W = 32
) (
  input  logic [NUM-1:0] map_i,
  output find_t          res_o
);
  localparam int WORDS = NUM / WORD_W;

  logic [WORDS-1:0] any_w;
  vec_t             idx_w [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_comb begin
      any_w[g] = 1'b0;
      idx_w[g] = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (map_i[g*WORD_W + b]) begin
          any_w[g] = 1'b1;
          idx_w[g] = VEC_W'(g*WORD_W + b);
        end
      end
    end
  end

  // upper words override lower ones
  always_comb begin
    res_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (any_w[w]) res_o = '{hit: 1'b1, idx: idx_w[w]};
    end
  end
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker
  import vpt_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int MIN_VEC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_en_i,
  input  logic             sw_en_i,
  input  logic             acc_valid_i,
  input  logic [VEC_W-1:0] acc_vec_i,
  input  logic             acc_level_i,
  output logic             acc_taken_o,
  output logic             acc_drop_o,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             cls_we_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic [CLS_W-1:0] cls_o,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_valid_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic             eoi_bc_o,
  output logic [VEC_W-1:0] eoi_bc_vec_o
);
  localparam int LO_W = VEC_W - CLS_W;

  logic [NUM_VEC-1:0] irr, isr, tmr;
  find_t hp, hs;
  vec_t  tpr_q, isr_top, ppr;
  logic  en, deliv, ack_go, eoi_go, pend_eff, acc_take;
  logic  taken_q, drop_q, bc_q;
  vec_t  bc_vec_q;

  vpt_find #(.NUM(NUM_VEC), .WORD_W(WORD_W)) u_find_irr (.map_i(irr), .res_o(hp));
  vpt_find #(.NUM(NUM_VEC), .WORD_W(WORD_W)) u_find_isr (.map_i(isr), .res_o(hs));

  assign en      = hw_en_i & sw_en_i;
  assign isr_top = hs.hit ? hs.idx : '0;
  assign ppr     = (tpr_q[VEC_W-1:LO_W] >= isr_top[VEC_W-1:LO_W])
                   ? tpr_q : {isr_top[VEC_W-1:LO_W], {LO_W{1'b0}}};
  assign deliv   = en && hp.hit && (hp.idx[VEC_W-1:LO_W] > ppr[VEC_W-1:LO_W]);

  assign ack_go   = ack_i & deliv;
  assign eoi_go   = eoi_i & hs.hit;
  // acknowledge clear is ordered before the accept set
  assign pend_eff = irr[acc_vec_i] & ~(ack_go && (hp.idx == acc_vec_i));
  assign acc_take = acc_valid_i && en && (int'(acc_vec_i) >= MIN_VEC)
                    && !(pend_eff && acc_level_i);

  vpt_map #(.NUM(NUM_VEC), .WORD_W(WORD_W)) u_irr (
    .clk_i, .rst_ni,
    .clr_en_i(ack_go),   .clr_idx_i(hp.idx),
    .wr_en_i (acc_take), .wr_idx_i (acc_vec_i), .wr_val_i(1'b1),
    .map_o   (irr)
  );

  vpt_map #(.NUM(NUM_VEC), .WORD_W(WORD_W)) u_isr (
    .clk_i, .rst_ni,
    .clr_en_i(eoi_go), .clr_idx_i(hs.idx),
    .wr_en_i (ack_go), .wr_idx_i (hp.idx), .wr_val_i(1'b1),
    .map_o   (isr)
  );

  vpt_map #(.NUM(NUM_VEC), .WORD_W(WORD_W)) u_tmr (
    .clk_i, .rst_ni,
    .clr_en_i(eoi_go),   .clr_idx_i(hs.idx),
    .wr_en_i (acc_take), .wr_idx_i (acc_vec_i), .wr_val_i(acc_level_i),
    .map_o   (tmr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q    <= '0;
      taken_q  <= 1'b0;
      drop_q   <= 1'b0;
      bc_q     <= 1'b0;
      bc_vec_q <= '0;
    end else begin
      if (tpr_we_i)      tpr_q <= tpr_i;
      else if (cls_we_i) tpr_q <= {cls_i, {LO_W{1'b0}}};
      taken_q <= acc_take;
      drop_q  <= acc_valid_i & ~acc_take;
      bc_q    <= eoi_go & tmr[hs.idx];
      if (eoi_go) bc_vec_q <= hs.idx;
    end
  end

  assign acc_taken_o  = taken_q;
  assign acc_drop_o   = drop_q;
  assign cls_o        = tpr_q[VEC_W-1:LO_W];
  assign irq_valid_o  = deliv;
  assign irq_vec_o    = hp.idx;
  assign ppr_o        = ppr;
  assign eoi_bc_o     = bc_q;
  assign eoi_bc_vec_o = bc_vec_q;
endmodule

// File: rtl/vpt_checker.sv
module vpt_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hw_en_i,
  input logic       sw_en_i,
  input logic       acc_valid_i,
  input logic [7:0] acc_vec_i,
  input logic       eoi_i,
  input logic       irq_valid_o,
  input logic [7:0] irq_vec_o,
  input logic [7:0] ppr_o,
  input logic [3:0] cls_o,
  input logic       acc_taken_o,
  input logic       acc_drop_o,
  input logic       eoi_bc_o,
  input logic [7:0] eoi_bc_vec_o
);
  assert_ppr_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o[7:4] >= cls_o);

  assert_deliver_class_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_vec_o[7:4] > ppr_o[7:4]));

  assert_deliver_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_vec_o >= 8'd16));

  assert_disabled_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hw_en_i && sw_en_i) |-> !irq_valid_o);

  assert_disabled_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && (!(hw_en_i && sw_en_i) || acc_vec_i < 8'd16)) |=> acc_drop_o);

  assert_accept_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_taken_o || acc_drop_o) |-> $past(acc_valid_i));

  assert_accept_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_taken_o && acc_drop_o));

  assert_bc_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bc_o |-> ($past(eoi_i) && eoi_bc_vec_o >= 8'd16));

  assert_bc_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_bc_o && !$past(eoi_i, 2)) |=> !eoi_bc_o || $past(eoi_i));
endmodule

bind vec_prio_tracker vpt_checker u_chk (.*);

// File: tb/vec_prio_tracker_bench.sv
module vec_prio_tracker_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_en = 0, sw_en = 0, acc_valid = 0, acc_level = 0;
  logic [7:0] acc_vec = 0, tpr_v = 0;
  logic tpr_we = 0, cls_we = 0, ack = 0, eoi = 0;
  logic [3:0] cls_v = 0;
  logic acc_taken, acc_drop, irq_valid, eoi_bc;
  logic [3:0] cls_rd;
  logic [7:0] irq_vec, ppr, eoi_bc_vec;

  always #10 clk = ~clk;

  vec_prio_tracker u_vec_prio_tracker (
    .clk_i(clk), .rst_ni(rst_n), .hw_en_i(hw_en), .sw_en_i(sw_en),
    .acc_valid_i(acc_valid), .acc_vec_i(acc_vec), .acc_level_i(acc_level),
    .acc_taken_o(acc_taken), .acc_drop_o(acc_drop),
    .tpr_we_i(tpr_we), .tpr_i(tpr_v), .cls_we_i(cls_we), .cls_i(cls_v), .cls_o(cls_rd),
    .ack_i(ack), .eoi_i(eoi), .irq_valid_o(irq_valid), .irq_vec_o(irq_vec),
    .ppr_o(ppr), .eoi_bc_o(eoi_bc), .eoi_bc_vec_o(eoi_bc_vec)
  );

  // behavioural reference
  bit pend_m[256], serv_m[256], lvl_m[256];
  int tpr_m = 0;
  bit e_taken = 0, e_drop = 0, e_bc = 0;
  int e_bc_vec = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int top_of(input bit m[256]);
    for (int i = 255; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int prio_m();
    int s = top_of(serv_m);
    if (s < 0) s = 0;
    return ((tpr_m >> 4) >= (s >> 4)) ? tpr_m : (s & 'hF0);
  endfunction

  function automatic bit offer_m(output int v);
    v = top_of(pend_m);
    return hw_en && sw_en && v >= 0 && (v & 'hF0) > prio_m();
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int v;
    bit ok = offer_m(v);
    chk(tag, "irq_valid", irq_valid, ok);
    if (v >= 0) chk(tag, "irq_vec", irq_vec, v);
    chk(tag, "ppr", ppr, prio_m());
    chk(tag, "cls", cls_rd, tpr_m >> 4);
    chk(tag, "acc_taken", acc_taken, e_taken);
    chk(tag, "acc_drop", acc_drop, e_drop);
    chk(tag, "eoi_bc", eoi_bc, e_bc);
    if (e_bc) chk(tag, "eoi_bc_vec", eoi_bc_vec, e_bc_vec);
  endtask

  task automatic step(string tag, bit av, int avec, bit alvl, bit tw, int tv,
                      bit cw, int cv, bit ak, bit eo);
    int ov, s;
    bit ok;
    acc_valid = av; acc_vec = 8'(avec); acc_level = alvl;
    tpr_we = tw; tpr_v = 8'(tv); cls_we = cw; cls_v = 4'(cv); ack = ak; eoi = eo;
    ok = offer_m(ov);
    s  = top_of(serv_m);
    e_taken = 0; e_drop = 0; e_bc = 0;
    if (eo && s >= 0) begin
      serv_m[s] = 0;
      if (lvl_m[s]) begin lvl_m[s] = 0; e_bc = 1; e_bc_vec = s; end
    end
    if (ak && ok) begin serv_m[ov] = 1; pend_m[ov] = 0; end
    if (av) begin
      if (!(hw_en && sw_en) || avec < 16 || (pend_m[avec] && alvl)) e_drop = 1;
      else begin pend_m[avec] = 1; lvl_m[avec] = alvl; e_taken = 1; end
    end
    if (tw) tpr_m = tv;
    else if (cw) tpr_m = cv << 4;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic put(string tag, int v, bit lvl);
    step(tag, 1, v, lvl, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    idle("R1");
    hw_en = 1; sw_en = 1;
    put("R2", 'h35, 0);
    put("R2", 'h52, 1);
    put("R3", 'h52, 1);            // level repeat dropped
    put("R3", 'h35, 0);            // edge repeat taken
    put("R4", 'h05, 0);            // below 16
    sw_en = 0;
    put("R4", 'h60, 0);
    idle("R4");
    sw_en = 1;
    hw_en = 0;
    put("R4", 'h61, 1);
    hw_en = 1;
    idle("R4");
    step("R9", 0, 0, 0, 1, 'h55, 0, 0, 0, 0);   // class 5 blocks 0x52
    idle("R6");
    step("R9", 0, 0, 0, 0, 0, 1, 3, 0, 0);      // tpr = 0x30
    idle("R6");
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0);      // 0x52 in service
    step("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0);      // not deliverable: ignored
    idle("R5");
    put("R2", 'h90, 0);
    step("R10", 1, 'h90, 0, 0, 0, 0, 0, 1, 0);  // ack + accept same vector
    idle("R10");
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1);      // retire 0x90, edge: no pulse
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1);      // retire 0x52, level: pulse
    idle("R8");
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1);      // nothing in service
    step("R9", 0, 0, 0, 1, 'h27, 1, 'hC, 0, 0); // full write wins
    put("R2", 'h20, 1);
    step("R10", 1, 'h90, 1, 1, 0, 0, 0, 1, 0);  // level accept of acked vector taken
    step("R5", 0, 0, 0, 0, 0, 1, 'hA, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 2, 0, 0);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      sw_en = (r > 4);
      step("R11", $urandom_range(0, 2) != 0, $urandom_range(0, 255),
           1'($urandom_range(0, 1)), r < 3, $urandom_range(0, 255),
           r > 95, $urandom_range(0, 15), $urandom_range(0, 2) == 0,
           $urandom_range(0, 3) == 0);
    end
    sw_en = 1;
    for (int i = 0; i < 20; i++) step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule